// File: doc/BRIEF.md
# Countdown Execute Stage with Budgeted Writeback

This block is the execute and writeback end of an in-order pipeline. Each issued instruction carries a destination-register mask and a latency. It is dropped into a countdown array at the slot matching its latency. Every pipeline tick moves all slots one step toward slot zero. Slots keep only the union of their owners' destination masks, so instructions that meet in the same slot merge their pending writes.

The register file accepts only a small number of writes per cycle (one by default). The registers wanted by slot zero compete for these write ports, and the lowest register index wins. Granted writes leave the zero slot and clear their scoreboard bits. If any wanted write is left over, the stage raises `stall`. While `stall` is high the countdown freezes and new issues are refused, until the last write of slot zero is granted.

The scoreboard output `busy` tells the upstream decode logic which registers still have a result in flight.

Top module: `cdwb_stage`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge) `stall` is 0, `wb_mask` is all zero and `busy` is all zero. This holds even if writes were pending before the reset.
- R2: An issue is accepted at a rising edge where `iss_valid` is 1 and `stall` is 0. Its destinations first appear in `wb_mask` in the cycle after the L-th tick that follows the accepting edge, where L is `iss_lat` (0 to MAX_LAT). L = 0 means the accepting edge itself.
- R3: `wb_mask` (bit i = register i written this cycle) grants at most WPORTS registers per cycle. Grants are taken from the union of slot zero's destinations, lowest register index first.
- R4: `stall` is 1 exactly when slot zero still wants a write that is not granted this cycle. It drops to 0 in the cycle that grants the last remaining write.
- R5: While `stall` is 1, no slot advances and an issue request is ignored: it never sets `busy` and never reaches `wb_mask`.
- R6: A `busy` bit is set at the accepting edge for every destination of the issue. It is cleared at the edge where its write is granted. If the same register is granted and newly issued at the same edge, the bit stays set.
- R7: Instructions that land in the same countdown slot merge. A register wanted by both is written once.
- R8: An accepted issue with an all-zero destination mask changes neither `busy` nor any later `wb_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request this cycle |
| iss_lat | input | LAT_W | Cycles until completion, 0 to MAX_LAT |
| iss_dst | input | NREG | Destination-register mask of the issued instruction |
| stall | output | 1 | Leftover writes in slot zero; pipeline must not advance |
| wb_mask | output | NREG | Registers written to the register file this cycle |
| busy | output | NREG | Scoreboard: registers with a result still in flight |

## Verification
A wrong countdown slot shows at the ports as a `wb_mask` bit appearing one or more cycles early or late after its issue. The check samples every cycle of each latency path, so such an error is caught in the first misplaced cycle. A zero slot that is not cleared correctly keeps `stall` high, or releases it early. That shows as a wrong `stall` value in the very cycle the write budget runs out. A scoreboard that is out of step with the writeback shows as a `busy` bit that differs from the expected set in the cycle after the grant. The ignored issue made during a stall is watched on `busy` and on every later `wb_mask`.

// File: rtl/cdwb_pkg.sv
// Package: shared sizing helper for the countdown writeback stage.
// Assumes: latencies are counted in pipeline ticks starting at 0.
package cdwb_pkg;
    // Width of a latency field able to hold 0..max_lat.
    function automatic int lat_width(input int max_lat);
        return (max_lat < 1) ? 1 : $clog2(max_lat + 1);
    endfunction
endpackage

// File: rtl/cdwb_slots.sv
// Module: countdown array of destination masks, one mask per slot.
// Slot 0 is the completing slot. On a tick every slot takes its upper
// neighbour and a new issue ORs into slot `lat`. Without a tick only
// the granted writes are removed from slot 0.
// Assumes: a tick is only given when slot 0 is fully granted.
module cdwb_slots #(
    parameter int NREG    = 8,
    parameter int MAX_LAT = 3,
    parameter int LAT_W   = cdwb_pkg::lat_width(MAX_LAT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             acc,
    input  logic [LAT_W-1:0] lat,
    input  logic [NREG-1:0]  dst,
    input  logic [NREG-1:0]  grant,
    output logic [NREG-1:0]  zero_want
);
    localparam int DEPTH = MAX_LAT + 1;

    logic [DEPTH-1:0][NREG-1:0] slot_q;
    logic [DEPTH-1:0][NREG-1:0] slot_d;

    // Next-state of every slot: shift-and-insert on tick, drain slot 0 otherwise.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (tick) begin
                slot_d[i] = (i < DEPTH - 1) ? slot_q[(i < DEPTH - 1) ? i + 1 : i] : '0;
                if (acc && (lat == LAT_W'(i)))
                    slot_d[i] = slot_d[i] | dst;
            end else if (i == 0) begin
                slot_d[i] = slot_q[i] & ~grant;
            end else begin
                slot_d[i] = slot_q[i];
            end
        end
    end

    // Slot register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign zero_want = slot_q[0];

    // R5: a frozen cycle leaves every slot above zero untouched.
    a_r5_freeze_upper: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(slot_q[DEPTH-1:1]));

    // R4: a tick may only drop slot 0 once every wanted write was granted.
    a_r4_tick_only_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ((slot_q[0] & ~grant) == '0));
endmodule

// File: rtl/cdwb_arbiter.sv
// Module: fixed-priority write-port arbiter.
// Grants up to WPORTS of the wanted registers, lowest index first.
// Assumes: purely combinational; the caller registers the result.
module cdwb_arbiter #(
    parameter int NREG   = 8,
    parameter int WPORTS = 1
) (
    input  logic [NREG-1:0] want,
    output logic [NREG-1:0] grant
);
    // Walk registers from index 0 upward and hand out ports while any remain.
    always_comb begin
        int used;
        used  = 0;
        grant = '0;
        for (int r = 0; r < NREG; r++) begin
            if (want[r] && (used < WPORTS)) begin
                grant[r] = 1'b1;
                used     = used + 1;
            end
        end
    end
endmodule

// File: rtl/cdwb_scoreboard.sv
// Module: pending-write scoreboard.
// Sets the bits of accepted destinations and clears the bits of granted writes.
// Assumes: a new reservation wins over a grant at the same edge.
module cdwb_scoreboard #(
    parameter int NREG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc,
    input  logic [NREG-1:0] dst,
    input  logic [NREG-1:0] grant,
    output logic [NREG-1:0] busy
);
    logic [NREG-1:0] busy_q;
    logic [NREG-1:0] set_mask;

    // Destinations reserved this cycle.
    always_comb set_mask = acc ? dst : '0;

    // Scoreboard register: retire grants, then add new reservations.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= (busy_q & ~grant) | set_mask;
    end

    assign busy = busy_q;

    // R6: every accepted destination is reserved after the edge.
    a_r6_reserve: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ((busy_q & $past(dst)) == $past(dst)));

    // R6: a grant without a fresh reservation clears its bit.
    a_r6_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant & ~set_mask)) |=> ((busy_q & $past(grant & ~set_mask)) == '0));
endmodule

// File: rtl/cdwb_stage.sv
// Module: countdown execute stage with a budgeted register-file writeback.
// Issues enter the countdown array at their latency. Slot 0's wanted
// writes go through the port arbiter, and leftover writes raise stall,
// which freezes the countdown and refuses issues.
// Assumes: upstream holds its request while stall is high.
module cdwb_stage #(
    parameter int NREG    = 8,
    parameter int MAX_LAT = 3,
    parameter int WPORTS  = 1,
    parameter int LAT_W   = cdwb_pkg::lat_width(MAX_LAT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [LAT_W-1:0] iss_lat,
    input  logic [NREG-1:0]  iss_dst,
    output logic             stall,
    output logic [NREG-1:0]  wb_mask,
    output logic [NREG-1:0]  busy
);
    logic [NREG-1:0] want;
    logic [NREG-1:0] grant;
    logic            tick;
    logic            acc;

    // Leftover writes after arbitration freeze the pipeline.
    always_comb begin
        stall = |(want & ~grant);
        tick  = !stall;
        acc   = iss_valid && !stall;
    end

    cdwb_slots #(.NREG(NREG), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .tick(tick), .acc(acc),
        .lat(iss_lat), .dst(iss_dst), .grant(grant), .zero_want(want)
    );

    cdwb_arbiter #(.NREG(NREG), .WPORTS(WPORTS)) u_arb (
        .want(want), .grant(grant)
    );

    cdwb_scoreboard #(.NREG(NREG)) u_sb (
        .clk(clk), .rst_n(rst_n), .acc(acc), .dst(iss_dst),
        .grant(grant), .busy(busy)
    );

    assign wb_mask = grant;

    // R3: the write budget is never exceeded.
    a_r3_port_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wb_mask) <= WPORTS);

    // R3: the lowest wanted register is always among the grants.
    a_r3_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|want) |-> ((want & ((wb_mask & (~wb_mask + 1'b1)) - 1'b1)) == '0));

    // R4: a stalled cycle still spends write ports on slot 0.
    a_r4_stall_writes: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (wb_mask != '0));

    // R5: an issue during a stall adds no reservation.
    a_r5_ignore_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && iss_valid) |=> ((busy & ~$past(busy)) == '0));
endmodule

// File: tb/cdwb_stage_tb.sv
module cdwb_stage_tb;
    localparam int NREG = 8;
    localparam int MAX_LAT = 3;
    localparam int LAT_W = 2;
    localparam int NVEC = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 1'b0;
    logic [LAT_W-1:0] iss_lat = '0;
    logic [NREG-1:0] iss_dst = '0;
    logic stall;
    logic [NREG-1:0] wb_mask;
    logic [NREG-1:0] busy;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cdwb_stage #(.NREG(NREG), .MAX_LAT(MAX_LAT), .WPORTS(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_lat(iss_lat),
        .iss_dst(iss_dst), .stall(stall), .wb_mask(wb_mask), .busy(busy)
    );

    // Vector: {valid, lat[1:0], dst[7:0], exp_stall, exp_wb[7:0], exp_busy[7:0]}.
    // Expected values are the outputs in the cycle the inputs are applied.
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b1, 2'd2, 8'h01, 1'b0, 8'h00, 8'h00}, // 0  R1 state, issue A lat 2
        {1'b1, 2'd1, 8'h06, 1'b0, 8'h00, 8'h01}, // 1  B lat 1 merges with A (R7)
        {1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 8'h07}, // 2
        {1'b1, 2'd0, 8'h80, 1'b1, 8'h01, 8'h07}, // 3  R2 A and B due, R4 stall, R5 issue ignored
        {1'b0, 2'd0, 8'h00, 1'b1, 8'h02, 8'h06}, // 4  R3 next lowest
        {1'b1, 2'd0, 8'h10, 1'b0, 8'h04, 8'h04}, // 5  R4 last write, C lat 0
        {1'b1, 2'd3, 8'h04, 1'b0, 8'h10, 8'h10}, // 6  R2 C lat 0, D lat 3
        {1'b1, 2'd2, 8'h04, 1'b0, 8'h00, 8'h04}, // 7  E lat 2 meets D (R7)
        {1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 8'h04}, // 8
        {1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 8'h04}, // 9
        {1'b1, 2'd0, 8'h00, 1'b0, 8'h04, 8'h04}, // 10 R7 one write, R8 empty issue
        {1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 8'h00}, // 11 R8 nothing appears
        {1'b1, 2'd0, 8'hFF, 1'b0, 8'h00, 8'h00}, // 12 all registers
        {1'b1, 2'd1, 8'h01, 1'b1, 8'h01, 8'hFF}, // 13 R5 ignored issue
        {1'b0, 2'd0, 8'h00, 1'b1, 8'h02, 8'hFE}, // 14
        {1'b0, 2'd0, 8'h00, 1'b1, 8'h04, 8'hFC}, // 15
        {1'b0, 2'd0, 8'h00, 1'b1, 8'h08, 8'hF8}, // 16
        {1'b0, 2'd0, 8'h00, 1'b1, 8'h10, 8'hF0}, // 17
        {1'b0, 2'd0, 8'h00, 1'b1, 8'h20, 8'hE0}, // 18
        {1'b0, 2'd0, 8'h00, 1'b1, 8'h40, 8'hC0}, // 19
        {1'b1, 2'd0, 8'h80, 1'b0, 8'h80, 8'h80}, // 20 R6 reissue wins over grant
        {1'b0, 2'd0, 8'h00, 1'b0, 8'h80, 8'h80}, // 21
        {1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 8'h00}  // 22 R5 ignored reg0 never written
    };

    task automatic check(input string req, input string what,
                         input logic [NREG-1:0] got, input logic [NREG-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", "stall", NREG'(stall), '0);
        check("R1", "wb_mask", wb_mask, '0);
        check("R1", "busy", busy, '0);

        for (int k = 0; k < NVEC; k++) begin
            logic [27:0] v;
            v = VEC[k];
            iss_valid = v[27];
            iss_lat = v[26:25];
            iss_dst = v[24:17];
            #1;
            check("R4", "stall", NREG'(stall), NREG'(v[16]));
            check("R2/R3", "wb_mask", wb_mask, v[15:8]);
            check("R6", "busy", busy, v[7:0]);
            @(negedge clk);
        end

        // R1: reset while writes are pending
        iss_valid = 1'b1;
        iss_lat = 2'd0;
        iss_dst = 8'h03;
        @(negedge clk);
        iss_valid = 1'b0;
        #1;
        check("R1", "busy before reset", busy, 8'h03);
        check("R4", "stall before reset", NREG'(stall), NREG'(1));
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "stall after reset", NREG'(stall), '0);
        check("R1", "wb_mask after reset", wb_mask, '0);
        check("R1", "busy after reset", busy, '0);

        // R2: latency 3 alone; writeback in the cycle after the third following tick
        iss_valid = 1'b1;
        iss_lat = 2'd3;
        iss_dst = 8'h20;
        @(negedge clk);
        iss_valid = 1'b0;
        for (int c = 0; c < 3; c++) begin
            #1;
            check("R2", "wb_mask early", wb_mask, '0);
            @(negedge clk);
        end
        #1;
        check("R2", "wb_mask lat3", wb_mask, 8'h20);
        check("R6", "busy lat3", busy, 8'h20);
        @(negedge clk);
        #1;
        check("R6", "busy retired", busy, '0);

        finish_run();
    end
endmodule